// File: doc/BRIEF.md
# Keypad Matrix Row Scan Sequencer

This block scans a key matrix of up to six rows and eight columns. It pulls one row line low at a time, waits a programmable settling time, and samples the column lines. Each column line idles high, so a closed switch on the active row reads 0 and an open one reads 1. Several settings are programmed on static inputs:

- how many rows and how many columns are in use;
- two prescale stages whose product sets how long each row stays driven;
- a settling delay after every row change;
- an optional idle gap between complete passes over the matrix.

At the end of every row window the block presents the captured column vector, tagged with its row index, as a one-cycle strobe. A second strobe marks the end of a full pass. A flat 48-bit image of the whole matrix is also kept up to date. Debounce filtering, event flags and register access belong to neighbouring logic that consumes these outputs.

Scanning runs only while the enable input is high and the row setting is legal. Otherwise every row line is released and the block waits. Each new start begins at row 0.

Top module: `keypad_row_scanner`

## Requirements
- R1: `row_code` values 1 to 5 select 2 to 6 rows (`row_code`+1). Rows are driven in the order 0, 1, … up to the last row, then the order wraps to row 0. `sample_row` carries the index of the row just finished. Codes 0, 6 and 7 are illegal: no row is driven and `sample_valid` stays low.
- R2: `col_code` c (0 to 7) selects c+1 columns, with `col_in[i]` being column i. In `sample_cols`, bits above c read 1 whatever the column input shows.
- R3: Row r is driven by `row_drv_n[r]`=0, and at most one row bit is low at any time. A row window lasts W=(`psc`+1)·(`pscdiv`+1) cycles. Row 0 is first driven in the cycle after the enable is first seen high. `sample_valid` pulses for one cycle in the cycle that follows the last cycle of each window, and the next row is driven from that same cycle.
- R4: The reported vector is the value of `col_in` during window cycle S, counted from 0 at the row change. S is 4, 8, 16 or 32 for `settle_code` 0, 1, 2, 3. When W≤S, the value during the last window cycle is used instead. A pressed key reads 0.
- R5: With `scan_gap`=0, row 0 follows the last row's window at once. With `scan_gap`=N≠0, all rows stay released for N+1 cycles before row 0 is driven. No setting gives a one-cycle gap.
- R6: `scan_done` pulses only together with the `sample_valid` of the last row.
- R7: `key_state` bit r·8+c holds the last reported value for row r, column c. The bits of rows and columns outside the programmed matrix read 1. The vector is all ones while disabled.
- R8: While the enable is low, from the next cycle on all `row_drv_n` bits are 1 and no strobe is produced. Re-enabling restarts at row 0 with a full window.
- R9: After synchronous reset, `row_drv_n` is all ones, both strobes are low and `key_state` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan enable |
| row_code | input | 3 | Row count code (rows = code+1, 1..5 legal) |
| col_code | input | 3 | Column count code (columns = code+1) |
| psc | input | 8 | First prescale stage, divides by value+1 |
| pscdiv | input | 8 | Second prescale stage, divides by value+1 |
| settle_code | input | 2 | Settling delay select, 4·2^code cycles |
| scan_gap | input | 10 | Gap between passes: 0 none, else value+1 cycles |
| col_in | input | 8 | Column lines, 0 = pressed |
| row_drv_n | output | 6 | Active-low row drive |
| sample_valid | output | 1 | One-cycle strobe at each row window end |
| sample_row | output | 3 | Row index of the reported vector |
| sample_cols | output | 8 | Captured columns, unused ones forced to 1 |
| scan_done | output | 1 | Strobe at the end of a full pass |
| key_state | output | 48 | Matrix image, bit row·8+column |

## Verification
The window-length, settling-point, gap-length and last-row assertions take it for granted that the size, prescale, settle and gap inputs are held steady for as long as the enable is high. The stimulus therefore changes those inputs only after dropping the enable and waiting several cycles. Between such changes it mixes randomly drawn legal settings with directed ones: a long nominal window, the shortest window, windows just shorter, equal to and longer than the settling delay, a gap of one and of 1023, the three illegal row codes, and a disable in the middle of a pass. The simulated key matrix shows the inverted key pattern on every cycle except the one where capture is expected. A vector taken on the wrong cycle therefore shows up at once.

// File: rtl/kps_pkg.sv
package kps_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_ROW  = 2'd1,
    SCAN_GAP  = 2'd2
  } scan_state_e;

  // Settling delay in cycles: 2^(min_log + code)
  function automatic int settle_cycles(input int min_log, input logic [1:0] code);
    return 1 << (min_log + int'(code));
  endfunction

endpackage

// File: rtl/kps_prescaler.sv
// Two cascaded dividers; win_end marks the last cycle of a row window.
module kps_prescaler #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [DIV_W-1:0] pscdiv,
  output logic             win_end
);

  logic [PSC_W-1:0] pc_q;
  logic [DIV_W-1:0] dc_q;
  logic             pc_wrap;

  assign pc_wrap = (pc_q == psc);
  assign win_end = run && pc_wrap && (dc_q == pscdiv);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc_q <= '0;
      dc_q <= '0;
    end else if (pc_wrap) begin
      pc_q <= '0;
      dc_q <= (dc_q == pscdiv) ? '0 : dc_q + 1'b1;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // Counters stay inside the programmed ranges while the window runs
  assert_div_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pc_q <= psc) && (dc_q <= pscdiv));

endmodule

// File: rtl/kps_settle.sv
// Picks the single cycle of a row window on which the columns are captured.
module kps_settle #(
  parameter int SETTLE_MIN_LOG = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       win_end,
  input  logic [1:0] code,
  output logic       capture
);
  import kps_pkg::*;

  localparam int CNT_W = SETTLE_MIN_LOG + 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             taken_q;

  assign target  = CNT_W'(settle_cycles(SETTLE_MIN_LOG, code));
  assign capture = run && !taken_q && ((cnt_q == target) || win_end);

  always_ff @(posedge clk) begin
    if (rst || !run || win_end) begin
      cnt_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      if (capture) taken_q <= 1'b1;
      if (!taken_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Once captured, a window takes no second sample
  assert_capture_once_R4: assert property (@(posedge clk) disable iff (rst)
    (run && taken_q && !win_end) |=> !capture);

endmodule

// File: rtl/kps_gap.sv
// Counts the idle cycles between complete passes.
module kps_gap #(
  parameter int GAP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [GAP_W-1:0] gap,
  output logic             gap_last
);

  logic [GAP_W-1:0] cnt_q;

  assign gap_last = run && (cnt_q == gap);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // A gap phase is only entered with a nonzero setting
  assert_gap_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (gap != '0) && (cnt_q <= gap));

endmodule

// File: rtl/kps_key_store.sv
// One register per row holding the latest column vector of that row.
module kps_key_store #(
  parameter int MAX_ROWS = 6,
  parameter int MAX_COLS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         wr_en,
  input  logic [$clog2(MAX_ROWS)-1:0]  wr_row,
  input  logic [MAX_COLS-1:0]          wr_cols,
  output logic [MAX_ROWS*MAX_COLS-1:0] key_state
);

  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_row
    logic [MAX_COLS-1:0] row_q;
    always_ff @(posedge clk) begin
      if (rst || clear)                      row_q <= '1;
      else if (wr_en && int'(wr_row) == r)   row_q <= wr_cols;
    end
    assign key_state[r*MAX_COLS +: MAX_COLS] = row_q;
  end

  assert_clear_released_R7: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (&key_state));

endmodule

// File: rtl/keypad_row_scanner.sv
module keypad_row_scanner
  import kps_pkg::*;
#(
  parameter int MAX_ROWS       = 6,
  parameter int MAX_COLS       = 8,
  parameter int PSC_W          = 8,
  parameter int DIV_W          = 8,
  parameter int GAP_W          = 10,
  parameter int SETTLE_MIN_LOG = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic [$clog2(MAX_ROWS)-1:0]  row_code,
  input  logic [$clog2(MAX_COLS)-1:0]  col_code,
  input  logic [PSC_W-1:0]             psc,
  input  logic [DIV_W-1:0]             pscdiv,
  input  logic [1:0]                   settle_code,
  input  logic [GAP_W-1:0]             scan_gap,
  input  logic [MAX_COLS-1:0]          col_in,
  output logic [MAX_ROWS-1:0]          row_drv_n,
  output logic                         sample_valid,
  output logic [$clog2(MAX_ROWS)-1:0]  sample_row,
  output logic [MAX_COLS-1:0]          sample_cols,
  output logic                         scan_done,
  output logic [MAX_ROWS*MAX_COLS-1:0] key_state
);

  localparam int ROW_IDX_W = $clog2(MAX_ROWS);
  localparam int WIN_W     = PSC_W + DIV_W;

  scan_state_e          st_q, st_d;
  logic [ROW_IDX_W-1:0] row_q, row_d, last_row;
  logic                 cfg_ok, go;
  logic                 win_end, capture, gap_last, row_done;
  logic [MAX_COLS-1:0]  col_mask, col_now, cap_q, row_result;

  // Legal row codes: 1 .. MAX_ROWS-1 (rows = code + 1)
  assign cfg_ok   = (row_code != '0) && (int'(row_code) <= MAX_ROWS - 1);
  assign last_row = row_code;
  assign go       = enable && cfg_ok;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_mask
    assign col_mask[c] = (c <= int'(col_code));
  end

  assign col_now    = col_in | ~col_mask;
  assign row_done   = go && (st_q == SCAN_ROW) && win_end;
  assign row_result = capture ? col_now : cap_q;

  kps_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == SCAN_ROW),
    .psc     (psc),
    .pscdiv  (pscdiv),
    .win_end (win_end)
  );

  kps_settle #(.SETTLE_MIN_LOG(SETTLE_MIN_LOG)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == SCAN_ROW),
    .win_end (win_end),
    .code    (settle_code),
    .capture (capture)
  );

  kps_gap #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .run      (st_q == SCAN_GAP),
    .gap      (scan_gap),
    .gap_last (gap_last)
  );

  kps_key_store #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clear     (!go),
    .wr_en     (row_done),
    .wr_row    (row_q),
    .wr_cols   (row_result),
    .key_state (key_state)
  );

  always_comb begin
    st_d  = st_q;
    row_d = row_q;
    case (st_q)
      SCAN_IDLE: begin
        st_d  = SCAN_ROW;
        row_d = '0;
      end
      SCAN_ROW: begin
        if (win_end) begin
          if (row_q == last_row) begin
            row_d = '0;
            st_d  = (scan_gap != '0) ? SCAN_GAP : SCAN_ROW;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      SCAN_GAP: begin
        if (gap_last) begin
          st_d  = SCAN_ROW;
          row_d = '0;
        end
      end
      default: begin
        st_d  = SCAN_IDLE;
        row_d = '0;
      end
    endcase
    if (!go) begin
      st_d  = SCAN_IDLE;
      row_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= SCAN_IDLE;
      row_q        <= '0;
      row_drv_n    <= '1;
      sample_valid <= 1'b0;
      scan_done    <= 1'b0;
      sample_row   <= '0;
      sample_cols  <= '1;
      cap_q        <= '1;
    end else begin
      st_q         <= st_d;
      row_q        <= row_d;
      row_drv_n    <= (st_d == SCAN_ROW) ? ~(MAX_ROWS'(1) << row_d) : '1;
      sample_valid <= row_done;
      scan_done    <= row_done && (row_q == last_row);
      if (capture) cap_q <= col_now;
      if (row_done) begin
        sample_row  <= row_q;
        sample_cols <= row_result;
      end
    end
  end

  // ---------------- checking logic ----------------
  logic [WIN_W-1:0] win_cyc;
  logic [GAP_W:0]   gap_cyc;
  int               settle_len;

  assign settle_len = settle_cycles(SETTLE_MIN_LOG, settle_code);

  always_ff @(posedge clk) begin
    if (rst || st_q != SCAN_ROW || win_end) win_cyc <= '0;
    else                                    win_cyc <= win_cyc + 1'b1;
    if (rst || st_q != SCAN_GAP)            gap_cyc <= '0;
    else                                    gap_cyc <= gap_cyc + 1'b1;
  end

  assert_win_len_R3: assert property (@(posedge clk) disable iff (rst)
    win_end |-> int'(win_cyc) == (int'(psc) + 1) * (int'(pscdiv) + 1) - 1);

  assert_one_row_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(~row_drv_n) <= 1);

  assert_capture_point_R4: assert property (@(posedge clk) disable iff (rst)
    capture |-> (int'(win_cyc) == settle_len) || (win_end && int'(win_cyc) < settle_len));

  assert_gap_len_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == SCAN_GAP && gap_last) |-> int'(gap_cyc) == int'(scan_gap));

  assert_done_last_R6: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> sample_valid && (sample_row == last_row));

  assert_row_range_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == SCAN_ROW) |-> (row_q <= last_row));

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!go) |-> (&row_drv_n) && !sample_valid);

endmodule

// File: tb/keypad_row_scanner_bench.sv
module keypad_row_scanner_bench;
  localparam int NR = 6;
  localparam int NC = 8;

  logic        clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [2:0]  row_code = 3'd0, col_code = 3'd0;
  logic [7:0]  psc = 8'd0, pscdiv = 8'd0;
  logic [1:0]  settle_code = 2'd0;
  logic [9:0]  scan_gap = 10'd0;
  logic [7:0]  col_in = 8'hFF;
  logic [5:0]  row_drv_n;
  logic        sample_valid, scan_done;
  logic [2:0]  sample_row;
  logic [7:0]  sample_cols;
  logic [47:0] key_state;

  logic [7:0]  pressed [NR];
  int n_chk = 0, n_bad = 0, ncyc = 0, scans_seen = 0, wd = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  keypad_row_scanner u_keypad_row_scanner (
    .clk(clk), .rst(rst), .enable(enable), .row_code(row_code), .col_code(col_code),
    .psc(psc), .pscdiv(pscdiv), .settle_code(settle_code), .scan_gap(scan_gap),
    .col_in(col_in), .row_drv_n(row_drv_n), .sample_valid(sample_valid),
    .sample_row(sample_row), .sample_cols(sample_cols), .scan_done(scan_done),
    .key_state(key_state)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, ncyc);
    end
  endtask

  function automatic int win_len();
    return (int'(psc) + 1) * (int'(pscdiv) + 1);
  endfunction
  function automatic int cap_index();
    int s = 4 << settle_code;
    return (s < win_len()) ? s : win_len() - 1;
  endfunction
  function automatic int gap_len();
    return (scan_gap == 0) ? 0 : int'(scan_gap) + 1;
  endfunction
  function automatic logic [7:0] col_mask();
    logic [7:0] m;
    for (int c = 0; c < NC; c++) m[c] = (c <= int'(col_code));
    return m;
  endfunction
  function automatic logic [7:0] exp_cols(input int r);
    return ~pressed[r] | ~col_mask();
  endfunction
  function automatic logic [47:0] exp_keys();
    logic [47:0] k = '1;
    for (int r = 0; r < NR; r++) if (r <= int'(row_code)) k[r*NC +: NC] = exp_cols(r);
    return k;
  endfunction
  function automatic bit go_now();
    return enable && row_code >= 3'd1 && row_code <= 3'd5;
  endfunction

  // Key matrix model and checker, both working at the falling edge
  logic [5:0] prev_rows = 6'h3F;
  int  kcyc = 0, exp_row = 0, next_due = 0;
  bit  prev_go = 1'b0, exp_active = 1'b0, after_last = 1'b0;

  always @(negedge clk) begin : mon
    logic [7:0] tru;
    bit g;
    ncyc++;
    if (row_drv_n != prev_rows) kcyc = 0; else kcyc++;
    prev_rows = row_drv_n;
    tru = 8'hFF;
    for (int r = 0; r < NR; r++) if (!row_drv_n[r]) tru &= ~pressed[r];
    if (&row_drv_n) col_in = 8'hFF;
    else            col_in = (kcyc == cap_index()) ? tru : ~tru;

    if (mon_en) begin
      g = go_now();
      if (sample_valid) begin
        if (!exp_active) begin
          chk(1'b0, "R8 strobe while idle", 64'(sample_valid), 64'd0);
        end else begin
          chk(ncyc == next_due, after_last ? "R5 window end time" : "R3 window end time",
              64'(ncyc), 64'(next_due));
          chk(sample_row == 3'(exp_row), "R1 row order", 64'(sample_row), 64'(exp_row));
          chk((sample_cols & ~col_mask()) == ~col_mask(), "R2 unused columns",
              64'(sample_cols), 64'(sample_cols | ~col_mask()));
          chk(sample_cols == exp_cols(exp_row), "R4 captured columns",
              64'(sample_cols), 64'(exp_cols(exp_row)));
          chk(scan_done == (exp_row == int'(row_code)), "R6 pass strobe",
              64'(scan_done), 64'(exp_row == int'(row_code)));
          if (exp_row == int'(row_code)) begin
            chk(key_state == exp_keys(), "R7 matrix image", 64'(key_state), 64'(exp_keys()));
            scans_seen++;
            exp_row    = 0;
            after_last = 1'b1;
            next_due   = ncyc + gap_len() + win_len();
          end else begin
            exp_row++;
            after_last = 1'b0;
            next_due   = ncyc + win_len();
          end
        end
      end else if (exp_active && ncyc == next_due) begin
        chk(1'b0, "R3 missing strobe", 64'd0, 64'd1);
      end
      if (scan_done && !sample_valid) chk(1'b0, "R6 lone pass strobe", 64'd1, 64'd0);
      if (g && prev_go && exp_active && !(&row_drv_n))
        chk(row_drv_n == ~(6'd1 << exp_row), "R3 row drive", 64'(row_drv_n),
            64'(~(6'd1 << exp_row)));
      if (g && !prev_go) begin
        exp_active = 1'b1;
        exp_row    = 0;
        after_last = 1'b0;
        next_due   = ncyc + 1 + win_len();
      end
      if (!g) begin
        if (!prev_go) begin
          chk((&row_drv_n) && !sample_valid && !scan_done,
              (row_code == 0 || row_code > 5) ? "R1 illegal row code idle" : "R8 disabled idle",
              64'({row_drv_n, sample_valid}), 64'({6'h3F, 1'b0}));
          chk(key_state == '1, "R7 image released when idle", 64'(key_state), 64'hFFFF_FFFF_FFFF);
        end
        exp_active = 1'b0;
      end
      prev_go = g;
    end
  end

  task automatic stop_scan();
    @(posedge clk); #1 enable = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic setup(input logic [2:0] rc, input logic [2:0] cc, input logic [7:0] p,
                       input logic [7:0] d, input logic [1:0] sc, input logic [9:0] gp);
    @(posedge clk); #1;
    enable = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    row_code = rc; col_code = cc; psc = p; pscdiv = d; settle_code = sc; scan_gap = gp;
    for (int r = 0; r < NR; r++) pressed[r] = 8'($urandom);
  endtask

  task automatic wait_scans(input int n);
    int target = scans_seen + n;
    while (scans_seen < target) @(posedge clk);
  endtask

  task automatic run_cfg(input logic [2:0] rc, input logic [2:0] cc, input logic [7:0] p,
                         input logic [7:0] d, input logic [1:0] sc, input logic [9:0] gp,
                         input int n);
    setup(rc, cc, p, d, sc, gp);
    enable = 1'b1;
    wait_scans(n);
    stop_scan();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer than 190000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int r = 0; r < NR; r++) pressed[r] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(row_drv_n == 6'h3F, "R9 rows released", 64'(row_drv_n), 64'h3F);
    chk(!sample_valid, "R9 strobe low", 64'(sample_valid), 64'd0);
    chk(!scan_done, "R9 pass strobe low", 64'(scan_done), 64'd0);
    chk(key_state == '1, "R9 image released", 64'(key_state), 64'hFFFF_FFFF_FFFF);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;

    // Nominal long window: 3 rows, 3 columns, 65 x 32 cycles
    run_cfg(3'd2, 3'd2, 8'h40, 8'h1F, 2'd0, 10'd0, 1);
    // Shortest window, full matrix, longest settle, shortest gap (2 cycles)
    run_cfg(3'd5, 3'd7, 8'd0, 8'd0, 2'd3, 10'd1, 3);
    // Longest gap, 2 rows x 1 column
    run_cfg(3'd1, 3'd0, 8'd1, 8'd2, 2'd1, 10'd1023, 2);
    // Window just shorter than, equal to and longer than the settle time
    run_cfg(3'd3, 3'd4, 8'd3, 8'd0, 2'd0, 10'd0, 2);
    run_cfg(3'd3, 3'd4, 8'd4, 8'd0, 2'd0, 10'd0, 2);
    run_cfg(3'd4, 3'd5, 8'd8, 8'd0, 2'd0, 10'd5, 2);

    // Illegal row codes keep the block idle
    foreach (pressed[i]) pressed[i] = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      setup((i == 0) ? 3'd0 : ((i == 1) ? 3'd6 : 3'd7), 3'd7, 8'd0, 8'd1, 2'd0, 10'd0);
      enable = 1'b1;
      repeat (60) @(posedge clk);
      stop_scan();
    end

    // Disable in the middle of a pass, then restart from row 0
    setup(3'd3, 3'd6, 8'd2, 8'd1, 2'd0, 10'd3);
    enable = 1'b1;
    repeat (37) @(posedge clk);
    #1 enable = 1'b0;
    repeat (3) @(posedge clk);
    #1 enable = 1'b1;
    wait_scans(2);
    stop_scan();

    // Random legal settings
    for (int i = 0; i < 40; i++) begin
      logic [9:0] gp;
      gp = ($urandom_range(0, 1) == 0) ? 10'd0 : 10'($urandom_range(1, 12));
      run_cfg(3'($urandom_range(1, 5)), 3'($urandom_range(0, 7)), 8'($urandom_range(0, 5)),
              8'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), gp, 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule